// File: doc/BRIEF.md
# Prioritized ADC Sequencer Arbiter

Four conversion sequencers share one analog-to-digital converter, and this block decides which of them drives it. Each sequencer has an enable bit, a hardware trigger input and a programmed sequence length of one to eight conversion slots. A trigger arms its sequencer. The arbiter grants the converter to the highest-priority armed and enabled sequencer, then issues one start-of-conversion pulse per slot. It waits for the converter's end-of-conversion acknowledge between slots. A one-cycle DMA request for the owning sequencer follows every acknowledge.

A conversion that has started is never cut short. Two things can end a sequence early: a higher-priority sequencer arms, or software clears the owner's enable bit. In both cases the block lets the in-flight conversion finish and still raises its DMA request. It then discards the rest of that sequence. Software can poll a per-sequencer active output to learn when the last in-flight conversion of a stopped sequence has completed. Each sequencer also has an overflow flag. The flag records a trigger that arrived while that sequencer was already armed or running, and a write-one-to-clear strobe clears it.

Top module: `adc_seq_arbiter`

## Requirements
- R1: While reset is high, and in the cycle after it falls, every output is zero: conv_soc, conv_seq, conv_slot, dma_req, seq_done, seq_active and seq_ovf.
- R2: Sequencer index 0 has the highest priority and index 3 the lowest. When the converter is free, the lowest-numbered sequencer that is both enabled and armed is granted. Several sequencers triggered in the same cycle are therefore served in ascending index order.
- R3: A start-of-conversion pulse is never issued while a conversion is outstanding, that is between a conv_soc pulse and its conv_eoc. Every started conversion produces exactly one DMA request.
- R4: Field i of seq_len (bits 3i+2..3i) holds the slot count minus one, so a sequence has 1 to 8 slots. A granted sequence issues slots 0, 1, ... in order on conv_slot, with conv_seq carrying the sequencer index. A trigger in cycle k, with the converter free, gives conv_soc in cycle k+2. When the final slot's conversion ends, seq_done[i] pulses together with the final dma_req[i], and the sequencer returns to idle.
- R5: A higher-priority sequencer that arms while a lower one is converting waits until that conversion ends. It then takes the grant. The remaining slots of the lower sequence are discarded: no further conv_soc is issued for them and seq_done is not raised.
- R6: Clearing seq_en[i] while sequencer i is converting lets that conversion finish. Its dma_req[i] pulse is still raised. No further conversion starts for i, and seq_done[i] is not raised.
- R7: A trigger on a disabled sequencer is ignored. It arms nothing, sets no overflow, and is not remembered when the sequencer is enabled later. A disabled sequencer never delays the grant to an enabled one.
- R8: dma_req[i] is high for exactly one cycle, the cycle after conv_eoc is sampled high, where i is the owner of the finishing conversion. At most one dma_req bit is high at a time.
- R9: A trigger on an enabled sequencer that is already armed or active sets seq_ovf[i]. seq_ovf[i] stays set until a cycle with ovf_clr[i] high, and setting wins over clearing in the same cycle. Enabling or disabling any sequencer changes no overflow flag.
- R10: seq_active[i] rises in the cycle that carries the first conv_soc of a grant to i. It falls in the cycle after the conv_eoc of that sequence's last conversion. When a sequence is pre-empted, it falls instead in the cycle the new owner's first conv_soc appears.
- R11: Suppose the sequencer being serviced is disabled while another enabled sequencer is armed. The armed sequencer then receives its first conv_soc two cycles after the in-flight conversion's conv_eoc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_en | input | 4 | Enable bit per sequencer |
| seq_trig | input | 4 | Hardware trigger per sequencer, sampled each cycle |
| seq_len | input | 12 | Per-sequencer slot count minus one, 3 bits per sequencer |
| ovf_clr | input | 4 | Write-one-to-clear strobe for the overflow flags |
| conv_eoc | input | 1 | End-of-conversion acknowledge from the converter |
| conv_soc | output | 1 | One-cycle start-of-conversion request |
| conv_seq | output | 2 | Sequencer index owning the started conversion |
| conv_slot | output | 3 | Slot index of the started conversion |
| dma_req | output | 4 | One-cycle DMA request per sequencer |
| seq_done | output | 4 | One-cycle pulse when a sequence completes all its slots |
| seq_active | output | 4 | High while a sequence holds the converter |
| seq_ovf | output | 4 | Overflow flag per sequencer |

## Verification
The bench goes after the moments when ownership changes in the middle of a sequence, because that is where pre-emption or disabling happens.
- A design that aborted the in-flight conversion would lose the last DMA request of a stopped or pre-empted sequence.
- A design that deferred the decision by a slot would issue one conversion too many.
- A design that kept a discarded sequence around would resume it after the higher-priority sequence finishes.

The bench also triggers a sequencer while it is disabled and then enables it. A design that latched such a trigger would start a conversion no one asked for. Two further checks cover the overflow flags. An overflow raised by a repeated trigger must survive a neighbour being disabled. A clear strobe aimed at one sequencer must leave the others' flags set; a design that got this wrong would disturb or wipe the neighbouring flags.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int DEF_N_SEQ  = 4;
    localparam int DEF_SLOT_W = 3;

    typedef enum logic [0:0] {
        CH_IDLE = 1'b0,
        CH_ARMED = 1'b1
    } chan_state_t;
endpackage

// File: rtl/adc_seq_chan.sv
module adc_seq_chan
    import adc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic trig,
    input  logic grant,
    input  logic active,
    input  logic clr,
    output logic armed,
    output logic ovf
);
    chan_state_t state_q;
    logic        busy_now;

    assign busy_now = (state_q == CH_ARMED) || active;
    assign armed    = (state_q == CH_ARMED);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CH_IDLE;
            ovf     <= 1'b0;
        end else begin
            if (!en) begin
                state_q <= CH_IDLE;
            end else if (state_q == CH_ARMED) begin
                if (grant) state_q <= CH_IDLE;
            end else if (trig && !active) begin
                state_q <= CH_ARMED;
            end

            if (en && trig && busy_now) begin
                ovf <= 1'b1;
            end else if (clr) begin
                ovf <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl #(
    parameter int N_SEQ  = 4,
    parameter int SLOT_W = 3,
    parameter int ID_W   = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_SEQ-1:0]        en,
    input  logic [N_SEQ-1:0]        armed,
    input  logic [N_SEQ*SLOT_W-1:0] slot_last,
    input  logic                    eoc,
    output logic [N_SEQ-1:0]        grant,
    output logic [N_SEQ-1:0]        active,
    output logic                    soc,
    output logic [ID_W-1:0]         soc_id,
    output logic [SLOT_W-1:0]       soc_slot,
    output logic [N_SEQ-1:0]        dma,
    output logic [N_SEQ-1:0]        done
);
    logic              busy_q;
    logic              own_vld_q;
    logic [ID_W-1:0]   own_id_q;
    logic [SLOT_W-1:0] slot_q;
    logic [N_SEQ-1:0]  own_oh;
    logic [N_SEQ-1:0]  cand;
    logic [ID_W-1:0]   pick;
    logic              pick_vld;
    logic [SLOT_W-1:0] own_last;
    logic              go_cont;
    logic              go_new;

    always_comb begin
        own_oh = '0;
        if (own_vld_q) own_oh[own_id_q] = 1'b1;
        cand     = en & (armed | own_oh);
        pick_vld = |cand;
        pick     = '0;
        for (int i = N_SEQ - 1; i >= 0; i--) begin
            if (cand[i]) pick = ID_W'(i);
        end
        own_last = slot_last[own_id_q*SLOT_W +: SLOT_W];
        go_cont  = !busy_q && pick_vld && own_vld_q && (pick == own_id_q);
        go_new   = !busy_q && pick_vld && !go_cont;
        grant    = '0;
        if (go_new) grant[pick] = 1'b1;
    end

    assign active = own_oh;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q    <= 1'b0;
            own_vld_q <= 1'b0;
            own_id_q  <= '0;
            slot_q    <= '0;
            soc       <= 1'b0;
            soc_id    <= '0;
            soc_slot  <= '0;
            dma       <= '0;
            done      <= '0;
        end else begin
            soc  <= 1'b0;
            dma  <= '0;
            done <= '0;
            if (!busy_q) begin
                if (go_new) begin
                    own_vld_q <= 1'b1;
                    own_id_q  <= pick;
                    slot_q    <= '0;
                    busy_q    <= 1'b1;
                    soc       <= 1'b1;
                    soc_id    <= pick;
                    soc_slot  <= '0;
                end else if (go_cont) begin
                    busy_q   <= 1'b1;
                    soc      <= 1'b1;
                    soc_id   <= own_id_q;
                    soc_slot <= slot_q;
                end else begin
                    own_vld_q <= 1'b0;
                end
            end else if (eoc) begin
                busy_q         <= 1'b0;
                dma[own_id_q]  <= 1'b1;
                if (slot_q == own_last) begin
                    done[own_id_q] <= 1'b1;
                    own_vld_q      <= 1'b0;
                    slot_q         <= '0;
                end else if (!en[own_id_q]) begin
                    own_vld_q <= 1'b0;
                end else begin
                    slot_q <= slot_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/adc_seq_arbiter.sv
module adc_seq_arbiter
    import adc_seq_pkg::*;
#(
    parameter int N_SEQ  = DEF_N_SEQ,
    parameter int SLOT_W = DEF_SLOT_W,
    localparam int ID_W  = $clog2(N_SEQ)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_SEQ-1:0]        seq_en,
    input  logic [N_SEQ-1:0]        seq_trig,
    input  logic [N_SEQ*SLOT_W-1:0] seq_len,
    input  logic [N_SEQ-1:0]        ovf_clr,
    input  logic                    conv_eoc,
    output logic                    conv_soc,
    output logic [ID_W-1:0]         conv_seq,
    output logic [SLOT_W-1:0]       conv_slot,
    output logic [N_SEQ-1:0]        dma_req,
    output logic [N_SEQ-1:0]        seq_done,
    output logic [N_SEQ-1:0]        seq_active,
    output logic [N_SEQ-1:0]        seq_ovf
);
    logic [N_SEQ-1:0] armed;
    logic [N_SEQ-1:0] grant;
    logic [N_SEQ-1:0] act;

    for (genvar g = 0; g < N_SEQ; g++) begin : g_chan
        adc_seq_chan u_chan (
            .clk    (clk),
            .rst    (rst),
            .en     (seq_en[g]),
            .trig   (seq_trig[g]),
            .grant  (grant[g]),
            .active (act[g]),
            .clr    (ovf_clr[g]),
            .armed  (armed[g]),
            .ovf    (seq_ovf[g])
        );
    end

    adc_conv_ctrl #(
        .N_SEQ  (N_SEQ),
        .SLOT_W (SLOT_W),
        .ID_W   (ID_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .en        (seq_en),
        .armed     (armed),
        .slot_last (seq_len),
        .eoc       (conv_eoc),
        .grant     (grant),
        .active    (act),
        .soc       (conv_soc),
        .soc_id    (conv_seq),
        .soc_slot  (conv_slot),
        .dma       (dma_req),
        .done      (seq_done)
    );

    assign seq_active = act;
endmodule

// File: rtl/adc_seq_arbiter_chk.sv
module adc_seq_arbiter_chk #(
    parameter int N_SEQ  = 4,
    parameter int ID_W   = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [N_SEQ-1:0] seq_en,
    input logic [N_SEQ-1:0] seq_trig,
    input logic [N_SEQ-1:0] ovf_clr,
    input logic             conv_eoc,
    input logic             conv_soc,
    input logic [ID_W-1:0]  conv_seq,
    input logic [N_SEQ-1:0] dma_req,
    input logic [N_SEQ-1:0] seq_done,
    input logic [N_SEQ-1:0] seq_active,
    input logic [N_SEQ-1:0] seq_ovf
);
    logic             outstanding;
    logic [N_SEQ-1:0] en_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            outstanding <= 1'b0;
            en_d        <= '0;
        end else begin
            en_d <= seq_en;
            if (conv_soc) outstanding <= 1'b1;
            else if (conv_eoc) outstanding <= 1'b0;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!conv_soc && dma_req == '0 && seq_active == '0 && seq_ovf == '0)); // R1
    AST_SOC_ENABLED: assert property (@(posedge clk) disable iff (rst) conv_soc |-> en_d[conv_seq]); // R2
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst) conv_soc |-> !outstanding); // R3
    AST_DMA_AFTER_EOC: assert property (@(posedge clk) disable iff (rst) (dma_req != '0) |-> $past(conv_eoc)); // R8
    AST_DMA_ONE: assert property (@(posedge clk) disable iff (rst) $onehot0(dma_req)); // R8
    AST_DONE_HAS_DMA: assert property (@(posedge clk) disable iff (rst) (seq_done & ~dma_req) == '0); // R4
    AST_ACTIVE_ONE: assert property (@(posedge clk) disable iff (rst) $onehot0(seq_active)); // R10
    AST_ACTIVE_AT_SOC: assert property (@(posedge clk) disable iff (rst) conv_soc |-> seq_active[conv_seq]); // R10
    AST_OVF_RISE: assert property (@(posedge clk) disable iff (rst) (seq_ovf & ~$past(seq_ovf) & ~$past(seq_trig & seq_en)) == '0); // R9
    AST_OVF_FALL: assert property (@(posedge clk) disable iff (rst) (~seq_ovf & $past(seq_ovf) & ~$past(ovf_clr)) == '0); // R9
endmodule

bind adc_seq_arbiter adc_seq_arbiter_chk #(
    .N_SEQ (N_SEQ),
    .ID_W  (ID_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .seq_en     (seq_en),
    .seq_trig   (seq_trig),
    .ovf_clr    (ovf_clr),
    .conv_eoc   (conv_eoc),
    .conv_soc   (conv_soc),
    .conv_seq   (conv_seq),
    .dma_req    (dma_req),
    .seq_done   (seq_done),
    .seq_active (seq_active),
    .seq_ovf    (seq_ovf)
);

// File: tb/adc_seq_arbiter_tb.sv
module adc_seq_arbiter_tb;
    localparam int N   = 4;
    localparam int SW  = 3;
    localparam int IW  = 2;
    localparam int LAT = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [N-1:0]    seq_en   = '0;
    logic [N-1:0]    seq_trig = '0;
    logic [N-1:0]    ovf_clr  = '0;
    logic [N*SW-1:0] seq_len  = '0;
    logic            conv_eoc = 1'b0;
    logic            conv_soc;
    logic [IW-1:0]   conv_seq;
    logic [SW-1:0]   conv_slot;
    logic [N-1:0]    dma_req, seq_done, seq_active, seq_ovf;

    adc_seq_arbiter u_dut (
        .clk(clk), .rst(rst), .seq_en(seq_en), .seq_trig(seq_trig),
        .seq_len(seq_len), .ovf_clr(ovf_clr), .conv_eoc(conv_eoc),
        .conv_soc(conv_soc), .conv_seq(conv_seq), .conv_slot(conv_slot),
        .dma_req(dma_req), .seq_done(seq_done), .seq_active(seq_active),
        .seq_ovf(seq_ovf)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_err = 0;

    // converter model and event log
    int lat_cnt = 0;
    int eoc_cyc = 0;
    int dma_bad = 0;
    int log_n   = 0;
    int log_seq  [256];
    int log_slot [256];
    int log_cyc  [256];
    int dma_cnt  [N] = '{default: 0};
    int done_cnt [N] = '{default: 0};

    always @(negedge clk) begin
        if (rst) begin
            conv_eoc = 1'b0;
            lat_cnt  = 0;
        end else begin
            if (dma_req != '0 && cyc != eoc_cyc + 1) dma_bad++;
            for (int i = 0; i < N; i++) begin
                if (dma_req[i]) dma_cnt[i]++;
                if (seq_done[i]) done_cnt[i]++;
            end
            conv_eoc = 1'b0;
            if (lat_cnt > 0) begin
                lat_cnt--;
                if (lat_cnt == 0) begin
                    conv_eoc = 1'b1;
                    eoc_cyc  = cyc;
                end
            end
            if (conv_soc && log_n < 256) begin
                lat_cnt = LAT;
                log_seq[log_n]  = int'(conv_seq);
                log_slot[log_n] = int'(conv_slot);
                log_cyc[log_n]  = cyc;
                log_n++;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_trig(input logic [N-1:0] m, output int tc);
        @(negedge clk);
        seq_trig = m;
        tc = cyc;
        @(negedge clk);
        seq_trig = '0;
    endtask

    task automatic wait_soc(input int base);
        while (log_n <= base) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_len(input int s, input int v);
        seq_len[s*SW +: SW] = SW'(v);
    endtask

    task automatic t_reset();
        idle(3);
        check("R1 soc in reset", int'(conv_soc), 0);
        check("R1 outputs in reset", int'({dma_req, seq_done, seq_active, seq_ovf}), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 outputs after reset", int'({conv_soc, dma_req, seq_active, seq_ovf}), 0);
    endtask

    task automatic t_single();
        int base, d0, n0, tc;
        seq_en = 4'b0010;
        set_len(1, 3);
        base = log_n; d0 = dma_cnt[1]; n0 = done_cnt[1];
        pulse_trig(4'b0010, tc);
        wait_soc(base);
        check("R10 active during sequence", int'(seq_active), 2);
        idle(60);
        check("R4 slot count", log_n - base, 4);
        for (int k = 0; k < 4; k++) begin
            check("R4 slot order", log_slot[base + k], k);
            check("R4 owner id", log_seq[base + k], 1);
        end
        check("R4 trigger to soc latency", log_cyc[base] - tc, 2);
        check("R8 dma count", dma_cnt[1] - d0, 4);
        check("R4 done pulse", done_cnt[1] - n0, 1);
        check("R10 active after last eoc", int'(seq_active), 0);
    endtask

    task automatic t_priority();
        int base, tc;
        seq_en = 4'b1111;
        seq_len = '0;
        base = log_n;
        pulse_trig(4'b0101, tc);
        idle(30);
        check("R2 two served", log_n - base, 2);
        check("R2 first is index0", log_seq[base], 0);
        check("R2 second is index2", log_seq[base + 1], 2);
        base = log_n;
        pulse_trig(4'b1110, tc);
        idle(40);
        check("R2 three served", log_n - base, 3);
        for (int k = 0; k < 3; k++) check("R2 ascending order", log_seq[base + k], k + 1);
    endtask

    task automatic t_preempt();
        int base, d3, n3, n0, tc;
        seq_en = 4'b1001;
        seq_len = '0;
        set_len(3, 7);
        base = log_n; d3 = dma_cnt[3]; n3 = done_cnt[3]; n0 = done_cnt[0];
        pulse_trig(4'b1000, tc);
        wait_soc(base);
        pulse_trig(4'b0001, tc);
        idle(80);
        check("R5 total conversions", log_n - base, 2);
        check("R5 low owner first", log_seq[base], 3);
        check("R5 high owner next", log_seq[base + 1], 0);
        check("R5 in-flight dma kept", dma_cnt[3] - d3, 1);
        check("R5 no done for discarded", done_cnt[3] - n3, 0);
        check("R5 high sequence done", done_cnt[0] - n0, 1);
    endtask

    task automatic t_disable();
        int base, d1, n1, tc;
        seq_en = 4'b0010;
        seq_len = '0;
        set_len(1, 3);
        base = log_n; d1 = dma_cnt[1]; n1 = done_cnt[1];
        pulse_trig(4'b0010, tc);
        wait_soc(base);
        @(negedge clk);
        seq_en = 4'b0000;
        @(negedge clk);
        check("R6 active while in flight", int'(seq_active[1]), 1);
        idle(40);
        check("R6 no further soc", log_n - base, 1);
        check("R6 last dma raised", dma_cnt[1] - d1, 1);
        check("R6 no done", done_cnt[1] - n1, 0);
        check("R10 active cleared", int'(seq_active), 0);
        seq_en = 4'b0010;
        idle(20);
        check("R6 not resumed on re-enable", log_n - base, 1);
        seq_en = 4'b0000;
    endtask

    task automatic t_handover();
        int base, tc;
        seq_en = 4'b1100;
        seq_len = '0;
        set_len(2, 3);
        base = log_n;
        pulse_trig(4'b0100, tc);
        wait_soc(base);
        pulse_trig(4'b1000, tc);
        seq_en = 4'b1000;
        idle(40);
        check("R11 conversions", log_n - base, 2);
        check("R11 next owner", log_seq[base + 1], 3);
        check("R11 handover gap", log_cyc[base + 1] - log_cyc[base], LAT + 2);
        check("R8 dma timing", dma_bad, 0);
    endtask

    task automatic t_ignore();
        int base, tc;
        seq_en = 4'b0000;
        seq_len = '0;
        base = log_n;
        pulse_trig(4'b0100, tc);
        idle(20);
        check("R7 disabled trigger no soc", log_n - base, 0);
        check("R7 disabled trigger no ovf", int'(seq_ovf), 0);
        seq_en = 4'b0100;
        idle(20);
        check("R7 trigger not latched", log_n - base, 0);
        seq_en = 4'b0010;
        pulse_trig(4'b0011, tc);
        idle(20);
        check("R7 only enabled served", log_n - base, 1);
        check("R7 enabled owner", log_seq[base], 1);
        check("R7 no delay from disabled", log_cyc[base] - tc, 2);
    endtask

    task automatic t_overflow();
        int base, tc;
        seq_en = 4'b0011;
        seq_len = '0;
        set_len(0, 1);
        base = log_n;
        pulse_trig(4'b0001, tc);
        wait_soc(base);
        pulse_trig(4'b0001, tc);
        idle(2);
        check("R9 overflow on busy trigger", int'(seq_ovf), 1);
        idle(40);
        check("R9 sequence not restarted", log_n - base, 2);
        pulse_trig(4'b0010, tc);
        pulse_trig(4'b0010, tc);
        idle(2);
        check("R9 second flag set", int'(seq_ovf), 3);
        seq_en = 4'b0010;
        idle(2);
        check("R9 disable keeps flags", int'(seq_ovf), 3);
        @(negedge clk); ovf_clr = 4'b0001;
        @(negedge clk); ovf_clr = 4'b0000;
        check("R9 clear one flag", int'(seq_ovf), 2);
        @(negedge clk); ovf_clr = 4'b0010;
        @(negedge clk); ovf_clr = 4'b0000;
        check("R9 clear other flag", int'(seq_ovf), 0);
        idle(30);
        seq_en = 4'b0000;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_single();
        t_priority();
        t_preempt();
        t_disable();
        t_handover();
        t_ignore();
        t_overflow();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule